// File: doc/BRIEF.md
# Ingress Granule DMA with Switch-Request Arbiter

This block sits between a set of per-port receive byte streams and a shared frame buffer. Each port delivers one byte per cycle with start-of-frame, end-of-frame and bad-status flags. The block keeps a tracker for each port that knows where the current frame stands. It packs the bytes into 8-byte granules and writes them to the buffer through a single write channel. A round-robin arbiter shares that channel among the ports.

Each frame gets a handle made from the port number and a per-port sequence count. The tracker also copies the frame's leading 64 bytes into a per-port header store. When a frame closes with good status, the port posts a switch request. A second round-robin arbiter picks one posted request at a time. It presents the request to the lookup engine with the source port, handle, frame length and captured header bytes, and holds it until the engine accepts it. A frame that closes bad posts no request. Instead the block flags its handle for release.

Top module: `ingress_granule_dma`

## Requirements
- R1: Frame byte k is written in the granule with wr_index = k/8, in byte lane k%8, which is wr_data bits [8*(k%8)+7 : 8*(k%8)]. Every granule that is not a frame's last carries wr_bytes = 8.
- R2: The granule holding a frame's final byte has wr_last = 1 and wr_bytes equal to its valid byte count (1 to 8). Its unused upper lanes read as zero.
- R3: A frame that ends with rx_bad = 0 raises sr_valid with sr_port, sr_handle and sr_len (the frame length in bytes). sr_valid rises only after the frame's last granule has appeared on the write channel.
- R4: A frame that ends with rx_bad = 1 raises no switch request. The cycle after its final byte is accepted, drop_valid[p] pulses for one cycle, with that frame's handle in drop_handle[p*HW +: HW].
- R5: Once sr_valid is high, it stays high with unchanged fields until a cycle with sr_ready = 1. The source port's rx_ready stays low from its good end of frame until that acceptance.
- R6: Pending switch requests are granted round-robin, starting from the port after the one granted last.
- R7: sr_hdr byte i (bits [8i+7:8i]) holds frame byte i for i < min(length, 64), and zero above that. sr_hdr_bytes = min(length, 64).
- R8: A frame handle is {port number, per-port sequence}. The sequence is 0 for a port's first frame after reset and rises by one for each frame started on that port, whether good or bad.
- R9: A byte offered on an idle port without rx_sof is consumed and discarded, with no write and no request. An rx_sof flag on a byte inside an open frame is ignored, and the byte is kept as ordinary frame data.
- R10: Ports with a completed granule share the write channel round-robin, with at most one granule per cycle. A port with an unwritten granule holds rx_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| rx_valid | input | NP | per-port byte valid |
| rx_data | input | NP*8 | per-port byte, port p at [8p+7:8p] |
| rx_sof | input | NP | byte is first of a frame |
| rx_eof | input | NP | byte is last of a frame |
| rx_bad | input | NP | frame status with rx_eof: 1 = bad |
| rx_ready | output | NP | port may present a byte |
| wr_valid | output | 1 | granule write strobe |
| wr_handle | output | HW | frame handle of the granule |
| wr_index | output | GW | granule number within the frame |
| wr_data | output | 64 | granule data, zero-padded |
| wr_bytes | output | 4 | valid bytes in the granule |
| wr_last | output | 1 | granule ends the frame |
| sr_valid | output | 1 | switch request pending |
| sr_ready | input | 1 | lookup engine accepts the request |
| sr_port | output | PW | source port |
| sr_handle | output | HW | frame handle |
| sr_len | output | LW | frame length in bytes |
| sr_hdr_bytes | output | 7 | valid header bytes |
| sr_hdr | output | 512 | first 64 frame bytes |
| drop_valid | output | NP | per-port release flag for a bad frame |
| drop_handle | output | NP*HW | handle to release, port p at [p*HW +: HW] |

## Verification
The bench uses frames of 5, 70 and 16 bytes. These cover a lone padded granule, a run of full granules with a ragged tail, and a header window that is cut at 64 bytes. Wrong lane placement, missing zero padding or a header that keeps stale bytes would each show up as a data mismatch. Requests are posted in the order port 2, then 0, 1, 3 while the lookup engine stalls. A fixed-priority arbiter would then grant 0 before 3, and one that dropped the hold would change sr_handle in mid-wait. A bad frame, sof-less bytes on an idle port and a stray sof inside a frame check that a request never comes from discarded data and that a stray flag never splits a frame.

// File: rtl/ingress_granule_dma.sv
module ingress_granule_dma #(
  parameter int NP    = 4,
  parameter int MAXB  = 2048,
  parameter int SEQ_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         rx_valid,
  input  logic [NP*8-1:0]       rx_data,
  input  logic [NP-1:0]         rx_sof,
  input  logic [NP-1:0]         rx_eof,
  input  logic [NP-1:0]         rx_bad,
  output logic [NP-1:0]         rx_ready,
  output logic                  wr_valid,
  output logic [((NP>1)?$clog2(NP):1)+SEQ_W-1:0] wr_handle,
  output logic [$clog2(MAXB+1)-4:0] wr_index,
  output logic [63:0]           wr_data,
  output logic [3:0]            wr_bytes,
  output logic                  wr_last,
  output logic                  sr_valid,
  input  logic                  sr_ready,
  output logic [((NP>1)?$clog2(NP):1)-1:0] sr_port,
  output logic [((NP>1)?$clog2(NP):1)+SEQ_W-1:0] sr_handle,
  output logic [$clog2(MAXB+1)-1:0] sr_len,
  output logic [6:0]            sr_hdr_bytes,
  output logic [511:0]          sr_hdr,
  output logic [NP-1:0]         drop_valid,
  output logic [NP*(((NP>1)?$clog2(NP):1)+SEQ_W)-1:0] drop_handle
);
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam int HW = PW + SEQ_W;
  localparam int LW = $clog2(MAXB + 1);
  localparam int GW = LW - 3;

  logic              act   [NP];
  logic              wsr   [NP];
  logic              gpend [NP];
  logic              glast [NP];
  logic [LW-1:0]     cnt   [NP];
  logic [LW-1:0]     flen  [NP];
  logic [2:0]        gcnt  [NP];
  logic [3:0]        gnb   [NP];
  logic [GW-1:0]     gidx  [NP];
  logic [63:0]       gbuf  [NP];
  logic [SEQ_W-1:0]  seq   [NP];
  logic [511:0]      hdr   [NP];

  logic              take  [NP];
  logic              start [NP];
  logic [LW-1:0]     pos   [NP];
  logic [2:0]        gc    [NP];
  logic [63:0]       nbuf  [NP];
  logic [511:0]      nhdr  [NP];

  logic [PW-1:0] wptr, wsel, sptr, ssl, ssel;
  logic          wany, sany, sbusy;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rx_ready[p] = !gpend[p] && !wsr[p];
      take[p]  = rx_valid[p] && rx_ready[p] && (act[p] || rx_sof[p]);
      start[p] = !act[p] && rx_sof[p];
      pos[p]   = start[p] ? '0 : cnt[p];
      gc[p]    = start[p] ? 3'd0 : gcnt[p];
      nbuf[p]  = (gc[p] == 3'd0) ? 64'd0 : gbuf[p];
      nbuf[p][{gc[p], 3'b000} +: 8] = rx_data[p*8 +: 8];
      nhdr[p]  = start[p] ? 512'd0 : hdr[p];
      if (pos[p] < LW'(64))
        nhdr[p][{pos[p][5:0], 3'b000} +: 8] = rx_data[p*8 +: 8];
    end
  end

  always_comb begin
    wany = 1'b0;
    wsel = wptr;
    sany = 1'b0;
    ssl  = sptr;
    for (int i = 1; i <= NP; i++) begin
      int k;
      k = (int'(wptr) + i) % NP;
      if (!wany && gpend[k]) begin
        wany = 1'b1;
        wsel = PW'(k);
      end
      k = (int'(sptr) + i) % NP;
      if (!sany && wsr[k] && !gpend[k]) begin
        sany = 1'b1;
        ssl  = PW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        act[p] <= 1'b0; wsr[p] <= 1'b0; gpend[p] <= 1'b0; glast[p] <= 1'b0;
        cnt[p] <= '0; flen[p] <= '0; gcnt[p] <= '0; gnb[p] <= '0;
        gidx[p] <= '0; gbuf[p] <= '0; seq[p] <= '1; hdr[p] <= '0;
      end
      wptr <= PW'(NP - 1);
      sptr <= PW'(NP - 1);
      ssel <= '0;
      sbusy <= 1'b0;
      wr_valid <= 1'b0;
      wr_handle <= '0; wr_index <= '0; wr_data <= '0; wr_bytes <= '0; wr_last <= 1'b0;
      drop_valid <= '0;
      drop_handle <= '0;
    end else begin
      drop_valid <= '0;
      wr_valid <= wany;
      if (wany) begin
        wr_handle <= {wsel, seq[wsel]};
        wr_index  <= gidx[wsel];
        wr_data   <= gbuf[wsel];
        wr_bytes  <= gnb[wsel];
        wr_last   <= glast[wsel];
        gpend[wsel] <= 1'b0;
        wptr <= wsel;
      end
      for (int p = 0; p < NP; p++) begin
        if (take[p]) begin
          gbuf[p] <= nbuf[p];
          hdr[p]  <= nhdr[p];
          cnt[p]  <= pos[p] + LW'(1);
          if (start[p]) seq[p] <= seq[p] + SEQ_W'(1);
          if (gc[p] == 3'd7 || rx_eof[p]) begin
            gpend[p] <= 1'b1;
            gnb[p]   <= {1'b0, gc[p]} + 4'd1;
            gidx[p]  <= pos[p][LW-1:3];
            glast[p] <= rx_eof[p];
            gcnt[p]  <= 3'd0;
          end else begin
            gcnt[p]  <= gc[p] + 3'd1;
          end
          if (rx_eof[p]) begin
            act[p] <= 1'b0;
            if (rx_bad[p]) begin
              drop_valid[p] <= 1'b1;
              drop_handle[p*HW +: HW] <= {PW'(p), start[p] ? seq[p] + SEQ_W'(1) : seq[p]};
            end else begin
              wsr[p]  <= 1'b1;
              flen[p] <= pos[p] + LW'(1);
            end
          end else begin
            act[p] <= 1'b1;
          end
        end
      end
      if (!sbusy && sany) begin
        sbusy <= 1'b1;
        ssel  <= ssl;
        sptr  <= ssl;
      end else if (sbusy && sr_ready) begin
        sbusy <= 1'b0;
        wsr[ssel] <= 1'b0;
      end
    end
  end

  assign sr_valid     = sbusy;
  assign sr_port      = ssel;
  assign sr_handle    = {ssel, seq[ssel]};
  assign sr_len       = flen[ssel];
  assign sr_hdr_bytes = (flen[ssel] >= LW'(64)) ? 7'd64 : flen[ssel][6:0];
  assign sr_hdr       = hdr[ssel];

  p_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_last |-> wr_bytes == 4'd8);

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_bytes != 4'd0) && (wr_bytes <= 4'd8));

  p_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_bytes < 4'd8 |-> (wr_data >> {wr_bytes, 3'b000}) == 64'd0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_valid && !sr_ready |=> sr_valid && $stable(sr_handle) && $stable(sr_len));

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_valid |-> !rx_ready[sr_port]);
endmodule

// File: tb/sim_ingress_granule_dma.sv
module sim_ingress_granule_dma;
  localparam int NP = 4;
  localparam int HW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [NP-1:0]   v, s, e, b;
  logic [7:0]      d [NP];
  logic [NP*8-1:0] rx_data;
  logic [NP-1:0]   rx_ready;
  logic            wr_valid, wr_last, sr_valid, sr_ready;
  logic [HW-1:0]   wr_handle, sr_handle;
  logic [8:0]      wr_index;
  logic [63:0]     wr_data;
  logic [3:0]      wr_bytes;
  logic [1:0]      sr_port;
  logic [11:0]     sr_len;
  logic [6:0]      sr_hdr_bytes;
  logic [511:0]    sr_hdr;
  logic [NP-1:0]   drop_valid;
  logic [NP*HW-1:0] drop_handle;

  for (genvar g = 0; g < NP; g++) begin : g_data
    assign rx_data[g*8 +: 8] = d[g];
  end

  ingress_granule_dma u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(v), .rx_data(rx_data), .rx_sof(s),
    .rx_eof(e), .rx_bad(b), .rx_ready(rx_ready), .wr_valid(wr_valid),
    .wr_handle(wr_handle), .wr_index(wr_index), .wr_data(wr_data),
    .wr_bytes(wr_bytes), .wr_last(wr_last), .sr_valid(sr_valid),
    .sr_ready(sr_ready), .sr_port(sr_port), .sr_handle(sr_handle),
    .sr_len(sr_len), .sr_hdr_bytes(sr_hdr_bytes), .sr_hdr(sr_hdr),
    .drop_valid(drop_valid), .drop_handle(drop_handle));

  int total = 0, fails = 0;
  int wn = 0, dn = 0, srseen = 0;
  logic [HW-1:0] lh [64];
  logic [8:0]    li [64];
  logic [63:0]   ld [64];
  logic [3:0]    lb [64];
  logic          ll [64];
  int            dport;
  logic [HW-1:0] dh;
  int            nseq [NP];

  always @(negedge clk) begin
    if (rst_n && wr_valid && wn < 64) begin
      lh[wn] = wr_handle; li[wn] = wr_index; ld[wn] = wr_data;
      lb[wn] = wr_bytes;  ll[wn] = wr_last;  wn++;
    end
    if (rst_n && sr_valid) srseen++;
    for (int p = 0; p < NP; p++)
      if (rst_n && drop_valid[p]) begin
        dn++; dport = p; dh = drop_handle[p*HW +: HW];
      end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] x);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, x);
    end
  endtask

  function automatic logic [HW-1:0] hnd(input int p, input int sq);
    return {2'(p), 4'(sq)};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int p, input int n, input bit bad, input logic [7:0] base, input int sofat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v[p] = 1'b1; d[p] = base + 8'(i);
      s[p] = (i == 0) || (i == sofat);
      e[p] = (i == n - 1); b[p] = bad && (i == n - 1);
      while (!rx_ready[p]) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    v[p] = 1'b0; s[p] = 1'b0; e[p] = 1'b0; b[p] = 1'b0;
    nseq[p]++;
  endtask

  task automatic expect_frame(input int p, input int n, input logic [7:0] base, input string tag);
    logic [HW-1:0] h;
    int ng;
    h  = hnd(p, nseq[p] - 1);
    ng = (n + 7) / 8;
    for (int g = 0; g < ng; g++) begin
      int f, nb;
      logic [63:0] x;
      f = -1;
      for (int k = 0; k < wn; k++) if (lh[k] == h && li[k] == 9'(g)) f = k;
      nb = (g == ng - 1) ? n - g * 8 : 8;
      x = '0;
      for (int j = 0; j < nb; j++) x[j*8 +: 8] = base + 8'(g * 8 + j);
      chk(f >= 0, {tag, " granule present"}, 64'(f), 64'(g));
      if (f >= 0) begin
        chk(ld[f] == x, {tag, " granule data"}, ld[f], x);
        chk(lb[f] == 4'(nb) && ll[f] == (g == ng - 1), {tag, " bytes/last"},
            {ll[f], lb[f]}, {(g == ng - 1), 4'(nb)});
      end
    end
  endtask

  task automatic ack(input int p, input int n, input logic [7:0] base, input int hold, input string tag);
    int w, bad_i, f;
    logic [HW-1:0] h;
    h = hnd(p, nseq[p] - 1);
    w = 0;
    while (!sr_valid && w < 400) begin @(negedge clk); w++; end
    chk(sr_valid, {tag, " R3 request raised"}, 64'(sr_valid), 1);
    f = -1;
    for (int k = 0; k < wn; k++) if (lh[k] == h && ll[k]) f = k;
    chk(f >= 0, {tag, " R3 last granule before request"}, 64'(f), 0);
    chk(sr_port == 2'(p) && sr_handle == h, {tag, " R6 R8 port/handle"},
        {sr_port, sr_handle}, {2'(p), h});
    chk(sr_len == 12'(n), {tag, " R3 length"}, 64'(sr_len), 64'(n));
    chk(sr_hdr_bytes == 7'((n > 64) ? 64 : n), {tag, " R7 header count"},
        64'(sr_hdr_bytes), 64'((n > 64) ? 64 : n));
    bad_i = -1;
    for (int i = 63; i >= 0; i--)
      if (sr_hdr[i*8 +: 8] != ((i < n) ? base + 8'(i) : 8'h00)) bad_i = i;
    chk(bad_i < 0, {tag, " R7 header bytes"}, 64'(bad_i), 64'hFFFF_FFFF_FFFF_FFFF);
    if (hold > 0) begin
      idle(hold);
      chk(sr_valid && sr_handle == h && !rx_ready[p], {tag, " R5 held until accepted"},
          {sr_valid, rx_ready[p], sr_handle}, {1'b1, 1'b0, h});
    end
    sr_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sr_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk(rx_ready == '1 && !wr_valid && !sr_valid && drop_valid == '0, "reset state",
        {rx_ready, wr_valid, sr_valid, drop_valid}, {4'hF, 1'b0, 1'b0, 4'h0});
  endtask

  task automatic t_short;
    wn = 0;
    send(1, 5, 1'b0, 8'hA0, -1);
    idle(3);
    expect_frame(1, 5, 8'hA0, "R2 short frame");
    ack(1, 5, 8'hA0, 0, "short");
  endtask

  task automatic t_long;
    wn = 0;
    send(0, 70, 1'b0, 8'h10, -1);
    idle(3);
    chk(wn == 9, "R1 granule count", 64'(wn), 9);
    expect_frame(0, 70, 8'h10, "R1 long frame");
    ack(0, 70, 8'h10, 10, "long");
  endtask

  task automatic t_bad;
    wn = 0; dn = 0; srseen = 0;
    send(2, 12, 1'b1, 8'h40, -1);
    idle(20);
    chk(dn == 1 && dport == 2 && dh == hnd(2, nseq[2] - 1), "R4 drop flag",
        {dn[7:0], dport[7:0], dh}, {8'd1, 8'd2, hnd(2, nseq[2] - 1)});
    chk(srseen == 0, "R4 no request for bad frame", 64'(srseen), 0);
    chk(wn == 2, "R4 granules still moved", 64'(wn), 2);
  endtask

  task automatic t_discard;
    wn = 0; srseen = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      v[3] = 1'b1; d[3] = 8'hEE; s[3] = 1'b0; e[3] = (i == 2); b[3] = 1'b0;
      chk(rx_ready[3], "R9 idle port consumes bytes", 64'(rx_ready[3]), 1);
      @(posedge clk);
    end
    @(negedge clk);
    v[3] = 1'b0; e[3] = 1'b0;
    idle(10);
    chk(wn == 0 && srseen == 0, "R9 discarded bytes leave no trace",
        64'(wn + srseen), 0);
    send(3, 11, 1'b0, 8'h70, 4);
    idle(3);
    expect_frame(3, 11, 8'h70, "R9 inner sof ignored");
    ack(3, 11, 8'h70, 0, "R9 frame");
    send(1, 9, 1'b0, 8'h33, -1);
    idle(3);
    ack(1, 9, 8'h33, 0, "R8 second frame");
    chk(nseq[1] == 2, "R8 sequence advanced", 64'(nseq[1]), 2);
  endtask

  task automatic t_rr_req;
    wn = 0;
    send(2, 4, 1'b0, 8'h20, -1);
    send(0, 6, 1'b0, 8'h50, -1);
    send(1, 7, 1'b0, 8'h60, -1);
    send(3, 3, 1'b0, 8'h90, -1);
    idle(3);
    ack(2, 4, 8'h20, 0, "R6 first");
    ack(3, 3, 8'h90, 0, "R6 second");
    ack(0, 6, 8'h50, 0, "R6 third");
    ack(1, 7, 8'h60, 0, "R6 fourth");
  endtask

  task automatic t_rr_wr;
    int prev, cur;
    wn = 0;
    fork
      send(0, 16, 1'b0, 8'h00, -1);
      send(1, 16, 1'b0, 8'h40, -1);
      send(2, 16, 1'b0, 8'h80, -1);
      send(3, 16, 1'b0, 8'hC0, -1);
    join
    idle(6);
    chk(wn == 8, "R10 granule count", 64'(wn), 8);
    chk(lh[0][5:4] != lh[1][5:4] && lh[1][5:4] != lh[2][5:4] && lh[2][5:4] != lh[3][5:4]
        && lh[0][5:4] != lh[2][5:4] && lh[0][5:4] != lh[3][5:4] && lh[1][5:4] != lh[3][5:4],
        "R10 four ports share four write cycles",
        {lh[0][5:4], lh[1][5:4], lh[2][5:4], lh[3][5:4]}, 8'b00011011);
    expect_frame(0, 16, 8'h00, "R10 port0");
    expect_frame(1, 16, 8'h40, "R10 port1");
    expect_frame(2, 16, 8'h80, "R10 port2");
    expect_frame(3, 16, 8'hC0, "R10 port3");
    prev = -1;
    for (int k = 0; k < 4; k++) begin
      int w;
      w = 0;
      while (!sr_valid && w < 100) begin @(negedge clk); w++; end
      cur = int'(sr_port);
      if (prev >= 0)
        chk(cur == (prev + 1) % NP, "R6 round-robin rotation", 64'(cur), 64'((prev + 1) % NP));
      prev = cur;
      ack(cur, 16, 8'(cur * 64), 0, "R6 rotation");
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sr_ready = 1'b0; v = '0; s = '0; e = '0; b = '0;
    for (int p = 0; p < NP; p++) begin d[p] = 8'h00; nseq[p] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short();
    t_long();
    t_bad();
    t_discard();
    t_rr_req();
    t_rr_wr();
    idle(4);
    finish_run();
  end
endmodule